// File: doc/BRIEF.md
# Serial Quad-Channel DAC Register Loader

This block is the digital front end of a four-channel 8-bit converter. A host shifts 12-bit command words in over a three-wire link (active-low select, serial clock, serial data). When the select line goes back high, the block decodes the last word received. That word carries the channel address, an 8-bit code and two active-low shutdown controls. The code is written into one of four input registers, and the software shutdown state of the channels is updated.

A second bank of four converter registers takes its values from the input registers under a level-sensitive, active-low load input. Because of this double buffering, all four channels can be preloaded and then changed together. An asynchronous active-low clear zeroes both banks. A hardware shutdown input forces every channel into shutdown without touching any register.

The serial pins are not used as clocks. Each one passes through a two-flop synchronizer into the system clock domain, and its edges are detected there. For this reason the system clock must run at least four times faster than the serial clock.

Top module: `qdl_serial_loader`

## Requirements
- R1: A command word is 12 bits and is shifted MSB first. Bit 11 is the active-low shutdown-all flag, bit 10 is the active-low shutdown-addressed flag, bits 9:8 are the channel address and bits 7:0 are the code.
- R2: A data bit is taken on each serial clock rising edge only while select is low. Serial clock edges seen while select is high leave the shift register unchanged.
- R3: On the rising edge of select, only the last 12 bits shifted are decoded. Any earlier bits are dropped, so a 16-bit transfer of two right-justified bytes works.
- R4: The address picks the input register: 0 selects channel A (bits 7:0 of dac_code), 1 selects B (15:8), 2 selects C (23:16) and 3 selects D (31:24).
- R5: A decoded word with bit 11 at 0 puts all four channels into software shutdown, whatever the value of bit 10.
- R6: A decoded word with bit 11 at 1 and bit 10 at 0 puts only the addressed channel into shutdown. The other channels keep their state.
- R7: A decoded word with both bits 11 and 10 at 1 releases software shutdown on the addressed channel only.
- R8: The code is written to the addressed input register even when the same word asserts a shutdown.
- R9: While load_n is low, each converter register takes its input register value one system clock later. While load_n is high, the converter registers hold.
- R10: A low level on clr_n zeroes all input and converter registers without waiting for a clock edge. It leaves the serial shift register and the shutdown state as they are.
- R11: After reset, all input and converter registers are 00h and no channel is in shutdown.
- R12: While hw_shdn is high, all four shdn bits read 1. The register contents are not changed, and the software shutdown state shows again once hw_shdn falls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low power-on reset |
| cs_n | input | 1 | Serial select, active low |
| sclk | input | 1 | Serial clock |
| sdi | input | 1 | Serial data, MSB first |
| load_n | input | 1 | Level-sensitive converter-register load, active low |
| clr_n | input | 1 | Asynchronous clear of both register banks, active low |
| hw_shdn | input | 1 | Hardware shutdown of all channels |
| dac_code | output | 32 | Converter register codes, channel A in bits 7:0 |
| shdn | output | 4 | Per-channel shutdown indication, bit 0 is channel A |

## Verification
A word can be decoded into an input register in the same cycle that the load level copies that register to its converter register. The bench holds load_n low while words arrive. It then expects the converter code to match the new input value once the pipeline has settled, never the value from before. A second overlap comes from a clear arriving after a word has been shifted but before the select is re-toggled. The bench judges this by re-raising select with no new clocks and checking that the old shift contents come through while everything else is still zero.

// File: rtl/qdl_pkg.sv
package qdl_pkg;
  localparam int DEF_DW  = 8;
  localparam int DEF_NCH = 4;

  typedef struct packed {
    logic rise;
    logic fall;
  } edges_t;

  function automatic edges_t detect(input logic cur, input logic prev);
    edges_t e;
    e.rise = cur & ~prev;
    e.fall = ~cur & prev;
    return e;
  endfunction
endpackage

// File: rtl/qdl_sync.sv
module qdl_sync #(
  parameter int         W       = 1,
  parameter int         STAGES  = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [STAGES-1:0][W-1:0] st;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st <= {STAGES{RST_VAL}};
    else        st <= {st[STAGES-2:0], d};
  end

  assign q = st[STAGES-1];
endmodule

// File: rtl/qdl_shifter.sv
module qdl_shifter #(
  parameter int CW = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cs_s,
  input  logic          sclk_s,
  input  logic          sdi_s,
  output logic [CW-1:0] word,
  output logic          shift_evt,
  output logic          commit
);
  import qdl_pkg::*;

  logic   cs_d, sclk_d;
  edges_t cs_e, sclk_e;
  logic [CW-1:0] shreg;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cs_d   <= 1'b1;
      sclk_d <= 1'b0;
    end else begin
      cs_d   <= cs_s;
      sclk_d <= sclk_s;
    end
  end

  assign cs_e      = detect(cs_s, cs_d);
  assign sclk_e    = detect(sclk_s, sclk_d);
  assign shift_evt = sclk_e.rise & ~cs_s;
  assign commit    = cs_e.rise;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         shreg <= '0;
    else if (shift_evt) shreg <= {shreg[CW-2:0], sdi_s};
  end

  assign word = shreg;
endmodule

// File: rtl/qdl_bank.sv
module qdl_bank #(
  parameter int DW  = 8,
  parameter int NCH = 4,
  parameter int AW  = 2,
  parameter int CW  = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr_n,
  input  logic              load_n,
  input  logic              commit,
  input  logic [CW-1:0]     word,
  output logic [NCH*DW-1:0] inp_flat,
  output logic [NCH*DW-1:0] dac_flat,
  output logic [NCH-1:0]    sw_sd
);
  logic          keep_all_n, keep_sel_n;
  logic [AW-1:0] addr;
  logic [DW-1:0] code;

  assign keep_all_n = word[CW-1];
  assign keep_sel_n = word[CW-2];
  assign addr       = word[DW+AW-1:DW];
  assign code       = word[DW-1:0];

  function automatic logic [NCH-1:0] sd_next(input logic [NCH-1:0] cur,
                                             input logic all_n,
                                             input logic sel_n,
                                             input logic [AW-1:0] a);
    logic [NCH-1:0] n;
    n = cur;
    if (!all_n)      n = '1;
    else if (!sel_n) n[a] = 1'b1;
    else             n[a] = 1'b0;
    return n;
  endfunction

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    logic [DW-1:0] inp_q, dac_q;

    always_ff @(posedge clk or negedge rst_n or negedge clr_n) begin
      if (!rst_n || !clr_n)                 inp_q <= '0;
      else if (commit && addr == AW'(i))    inp_q <= code;
    end

    always_ff @(posedge clk or negedge rst_n or negedge clr_n) begin
      if (!rst_n || !clr_n) dac_q <= '0;
      else if (!load_n)     dac_q <= inp_q;
    end

    assign inp_flat[i*DW +: DW] = inp_q;
    assign dac_flat[i*DW +: DW] = dac_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      sw_sd <= '0;
    else if (commit) sw_sd <= sd_next(sw_sd, keep_all_n, keep_sel_n, addr);
  end
endmodule

// File: rtl/qdl_serial_loader.sv
module qdl_serial_loader #(
  parameter int DW  = qdl_pkg::DEF_DW,
  parameter int NCH = qdl_pkg::DEF_NCH
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_n,
  input  logic              sclk,
  input  logic              sdi,
  input  logic              load_n,
  input  logic              clr_n,
  input  logic              hw_shdn,
  output logic [NCH*DW-1:0] dac_code,
  output logic [NCH-1:0]    shdn
);
  localparam int AW = $clog2(NCH);
  localparam int CW = 2 + AW + DW;

  logic          cs_s, sclk_s, sdi_s;
  logic [CW-1:0] word;
  logic          shift_evt, commit;
  logic [NCH*DW-1:0] inp_flat;
  logic [NCH-1:0]    sw_sd;

  qdl_sync #(.W(1), .STAGES(2), .RST_VAL(1'b1)) u_sync_cs (
    .clk(clk), .rst_n(rst_n), .d(cs_n), .q(cs_s));

  qdl_sync #(.W(2), .STAGES(2), .RST_VAL(2'b00)) u_sync_dat (
    .clk(clk), .rst_n(rst_n), .d({sclk, sdi}), .q({sclk_s, sdi_s}));

  qdl_shifter #(.CW(CW)) u_shift (
    .clk(clk), .rst_n(rst_n), .cs_s(cs_s), .sclk_s(sclk_s), .sdi_s(sdi_s),
    .word(word), .shift_evt(shift_evt), .commit(commit));

  qdl_bank #(.DW(DW), .NCH(NCH), .AW(AW), .CW(CW)) u_bank (
    .clk(clk), .rst_n(rst_n), .clr_n(clr_n), .load_n(load_n),
    .commit(commit), .word(word),
    .inp_flat(inp_flat), .dac_flat(dac_code), .sw_sd(sw_sd));

  assign shdn = sw_sd | {NCH{hw_shdn}};
endmodule

// File: rtl/qdl_checker.sv
module qdl_checker #(
  parameter int DW  = 8,
  parameter int NCH = 4,
  parameter int AW  = 2,
  parameter int CW  = 12
) (
  input logic              clk,
  input logic              rst_n,
  input logic              clr_n,
  input logic              load_n,
  input logic              hw_shdn,
  input logic              cs_s,
  input logic              commit,
  input logic [CW-1:0]     word,
  input logic [NCH*DW-1:0] inp_flat,
  input logic [NCH*DW-1:0] dac_code,
  input logic [NCH-1:0]    sw_sd,
  input logic [NCH-1:0]    shdn
);
  // R2: no shift register change after a cycle with select high
  a_r2_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
    cs_s |=> $stable(word));

  // R4 / R8: decoded code lands in the addressed input register
  a_r4_write: assert property (@(posedge clk) disable iff (!rst_n || !clr_n)
    (commit && clr_n) |=> inp_flat[$past(word[DW+AW-1:DW])*DW +: DW] == $past(word[DW-1:0]));

  // R5: shutdown-all flag
  a_r5_all: assert property (@(posedge clk) disable iff (!rst_n)
    (commit && !word[CW-1]) |=> sw_sd == '1);

  // R7: release of the addressed channel
  a_r7_release: assert property (@(posedge clk) disable iff (!rst_n)
    (commit && word[CW-1] && word[CW-2]) |=> !sw_sd[$past(word[DW+AW-1:DW])]);

  // R9: hold while load is high
  a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n || !clr_n)
    (load_n && clr_n) |=> $stable(dac_code));

  // R9: follow while load is low
  a_r9_follow: assert property (@(posedge clk) disable iff (!rst_n || !clr_n)
    (!load_n && clr_n) |=> dac_code == $past(inp_flat));

  // R10: clear level keeps both banks at zero
  a_r10_clear: assert property (@(posedge clk) disable iff (!rst_n)
    !clr_n |-> (dac_code == '0 && inp_flat == '0));

  // R12: hardware shutdown covers every channel
  a_r12_hw: assert property (@(posedge clk) disable iff (!rst_n)
    hw_shdn |-> shdn == '1);
endmodule

bind qdl_serial_loader qdl_checker #(.DW(DW), .NCH(NCH), .AW(AW), .CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .clr_n(clr_n), .load_n(load_n), .hw_shdn(hw_shdn),
  .cs_s(cs_s), .commit(commit), .word(word), .inp_flat(inp_flat),
  .dac_code(dac_code), .sw_sd(sw_sd), .shdn(shdn));

// File: tb/qdl_serial_loader_bench.sv
`timescale 1ns/1ps
module qdl_serial_loader_bench;
  localparam int HALF = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cs_n = 1'b1, sclk = 1'b0, sdi = 1'b0;
  logic load_n = 1'b1, clr_n = 1'b1, hw_shdn = 1'b0;
  logic [31:0] dac_code;
  logic [3:0]  shdn;

  always #2 clk = ~clk;

  qdl_serial_loader u_qdl_serial_loader (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sclk(sclk), .sdi(sdi),
    .load_n(load_n), .clr_n(clr_n), .hw_shdn(hw_shdn),
    .dac_code(dac_code), .shdn(shdn));

  typedef struct {
    logic [31:0] dac;
    logic [3:0]  sd;
    string       tag;
  } exp_t;
  exp_t q[$];

  int checks = 0, errors = 0;
  bit done = 0;

  logic [7:0]  m_inp [4];
  logic [7:0]  m_dac [4];
  logic [3:0]  m_sw;
  logic [11:0] m_sh;

  function automatic logic [11:0] mk(input bit all_n, input bit sel_n,
                                     input int a, input logic [7:0] c);
    return {all_n, sel_n, 2'(a), c};
  endfunction

  function automatic void model_word(input logic [11:0] w);
    int a;
    a = int'(w[9:8]);
    m_inp[a] = w[7:0];
    if (!w[11])      m_sw = 4'hF;
    else if (!w[10]) m_sw[a] = 1'b1;
    else             m_sw[a] = 1'b0;
    if (!load_n) for (int i = 0; i < 4; i++) m_dac[i] = m_inp[i];
  endfunction

  task automatic expect_now(input string tag);
    exp_t e;
    for (int i = 0; i < 4; i++) e.dac[i*8 +: 8] = m_dac[i];
    e.sd  = hw_shdn ? 4'hF : m_sw;
    e.tag = tag;
    q.push_back(e);
    @(negedge clk);
  endtask

  task automatic shift_bits(input logic [31:0] bits, input int n);
    for (int i = n - 1; i >= 0; i--) begin
      sdi = bits[i];
      repeat (HALF) @(negedge clk);
      sclk = 1'b1;
      if (!cs_n) m_sh = {m_sh[10:0], bits[i]};
      repeat (HALF) @(negedge clk);
      sclk = 1'b0;
    end
  endtask

  task automatic send(input logic [31:0] bits, input int n);
    cs_n = 1'b0;
    repeat (HALF) @(negedge clk);
    shift_bits(bits, n);
    repeat (HALF) @(negedge clk);
    cs_n = 1'b1;
    model_word(m_sh);
    repeat (12) @(negedge clk);
  endtask

  task automatic pulse_load();
    load_n = 1'b0;
    repeat (3) @(negedge clk);
    load_n = 1'b1;
    for (int i = 0; i < 4; i++) m_dac[i] = m_inp[i];
    repeat (2) @(negedge clk);
  endtask

  // monitor: pops expected items and compares against the ports
  initial begin
    exp_t e;
    forever begin
      wait (q.size() != 0);
      e = q.pop_front();
      checks++;
      if (dac_code !== e.dac || shdn !== e.sd) begin
        errors++;
        $display("FAIL %s: dac=%h shdn=%b expected dac=%h shdn=%b",
                 e.tag, dac_code, shdn, e.dac, e.sd);
      end
    end
  end

  initial begin
    #400000;
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 4; i++) begin m_inp[i] = 0; m_dac[i] = 0; end
    m_sw = 0;
    m_sh = 0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    expect_now("R11 reset state");

    // R1 R4 R9: write A with load high -> hold, then load
    send({20'h0, mk(1, 1, 0, 8'h5A)}, 12);
    expect_now("R9 hold while load high");
    pulse_load();
    expect_now("R1 R4 channel A after load");

    // R4 R9: transparent load, coincides with decode
    load_n = 1'b0;
    send({20'h0, mk(1, 1, 1, 8'h3C)}, 12);
    expect_now("R4 R9 channel B transparent");
    send({20'h0, mk(1, 1, 2, 8'hC3)}, 12);
    expect_now("R4 R9 channel C transparent");
    send({20'h0, mk(1, 1, 3, 8'hFF)}, 12);
    expect_now("R4 R9 channel D transparent");

    // R3: extra leading bits dropped
    send({16'h0, 4'hA, mk(1, 1, 1, 8'h81)}, 16);
    expect_now("R3 two-byte transfer");
    send({12'h0, 8'h5F, mk(1, 1, 3, 8'h42)}, 20);
    expect_now("R3 twenty-bit transfer");

    // R2: clocks with select high are ignored
    send({20'h0, mk(1, 1, 2, 8'h33)}, 12);
    shift_bits({20'h0, mk(0, 0, 2, 8'hCC)}, 12);
    repeat (8) @(negedge clk);
    expect_now("R2 clocks with select high");
    send(32'h0, 0);
    expect_now("R2 recommit of retained word");

    // R5 R6 R7 R8: shutdown handling
    send({20'h0, mk(0, 1, 0, 8'h11)}, 12);
    expect_now("R5 R8 shutdown all, code written");
    send({20'h0, mk(1, 1, 0, 8'h22)}, 12);
    expect_now("R7 release A only");
    send({20'h0, mk(1, 1, 1, 8'h44)}, 12);
    expect_now("R7 release B only");
    send({20'h0, mk(1, 0, 1, 8'h55)}, 12);
    expect_now("R6 R8 shutdown B only");
    send({20'h0, mk(0, 0, 3, 8'h66)}, 12);
    expect_now("R5 both flags low");
    send({20'h0, mk(1, 1, 0, 8'h77)}, 12);
    send({20'h0, mk(1, 1, 1, 8'h88)}, 12);
    expect_now("R7 sequential releases");

    // R12: hardware shutdown
    hw_shdn = 1'b1;
    repeat (2) @(negedge clk);
    expect_now("R12 hardware shutdown asserted");
    hw_shdn = 1'b0;
    repeat (2) @(negedge clk);
    expect_now("R12 hardware shutdown released");

    // R10: asynchronous clear
    load_n = 1'b1;
    repeat (2) @(negedge clk);
    #1 clr_n = 1'b0;
    for (int i = 0; i < 4; i++) begin m_inp[i] = 0; m_dac[i] = 0; end
    #0.5;
    checks++;
    if (dac_code !== 32'h0) begin
      errors++;
      $display("FAIL R10 async clear: dac=%h expected dac=%h", dac_code, 32'h0);
    end
    @(negedge clk);
    clr_n = 1'b1;
    repeat (2) @(negedge clk);
    expect_now("R10 clear keeps shutdown state");
    pulse_load();
    expect_now("R10 input bank cleared");
    send(32'h0, 0);
    pulse_load();
    expect_now("R10 shift register kept through clear");

    repeat (4) @(negedge clk);
    wait (q.size() == 0);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule